// File: doc/BRIEF.md
# Secure-Aware Interrupt Controller

This block gathers 128 level-sensitive interrupt inputs, grouped in four banks of 32, and presents them to a processor on two lines: a normal request line and a fast request line. Each input carries two state bits held in the block. An enable bit gates the input. A routing bit chooses the output line. Enables are changed through paired write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write. Routing bits are plain read/write words.

A global control word gates both request lines. A small priority threshold register and a synchronizer setting register are stored and read back. For low-power entry, software first asks for a deep-sleep holdoff. Once the holdoff is granted, software may load four wake mask words. While the holdoff stays granted, any asserted input whose wake bit is set raises a wake request, whether or not that input is enabled. A pending view gives each bank's asserted inputs masked by their enables.

The register interface is a simple word bus. Writes take effect on the clock edge where the write enable is high. Read data is registered and appears one cycle after the read enable.

Top module: `secure_intc`

## Requirements
- R1: After reset every enable, routing bit, wake bit, the control word, the threshold, the synchronizer setting and the holdoff flag are 0, and irq_o, fiq_o and wake_o are low.
- R2: A write to enable-set word b (byte offset 0x100 + 4*b) sets the enable of every source 32*b+i whose data bit i is 1 and leaves the others alone. Reading offset 0x100 + 4*b or 0x180 + 4*b returns bank b's enable bits.
- R3: A write to enable-clear word b (byte offset 0x180 + 4*b) clears the enable of every source whose data bit is 1 and leaves the others alone.
- R4: Routing word b at offset 0x080 + 4*b is read/write. irq_o is high when control bit 0 is 1 and some source is asserted, enabled and has routing bit 1. fiq_o is the same with routing bit 0.
- R5: When control bit 0 is 0, irq_o and fiq_o are low. The control word (0x000, 32 bits), the threshold (0x00C, low 5 bits) and the synchronizer setting (0x010, low 2 bits) read back what was written, with unimplemented upper bits reading 0.
- R6: Pending word b at offset 0xD00 + 4*b reads as bank b's input levels ANDed with its enable bits.
- R7: Writing 1 to bit 0 of the holdoff register (0x014) grants the holdoff, and it then reads as 1. The grant is refused, and the register reads 0, if at that write some source is asserted, enabled and routed to fiq_o. Writing 0 releases the holdoff.
- R8: Wake word b at offset 0xE00 + 4*b is always readable. A write to it takes effect only while the holdoff is granted; at other times the write is ignored.
- R9: wake_o is high exactly when the holdoff is granted and some asserted source has its wake bit set, regardless of enables.
- R10: Read data changes only on the cycle after rd_en_i and then holds. Offset 0x004 reads the source count (128). Offset 0x008 and offset 0xFD0 read fixed identification constants (0x00000A51 and 0x00000C31). Offsets 0xD80, 0xF00 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| src_i | input | 128 | Level interrupt inputs, source n on bit n |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request during deep-sleep holdoff |

## Verification
The routing function is driven with random sparse input levels over random mixes of enables and routing bits. This separates a wrong AND or OR term from a wrong bank or bit index, and shows whether a source reaches the wrong line. Directed patterns cover the corners. One source at bit 31 of the last bank tests the index edge. A set write mixed with zero bits shows that those bits are left alone. A control bit 0 of 0 with pending sources tests the gating. Wake words are written with the holdoff refused, granted and released, and the inputs are asserted while disabled. This tells apart wake gating from enable gating, and a wake write that is accepted from one that is dropped.

// File: rtl/sic_pkg.sv
package sic_pkg;
   localparam int unsigned OFS_CTRL  = 'h000;
   localparam int unsigned OFS_KIND  = 'h004;
   localparam int unsigned OFS_IMPL  = 'h008;
   localparam int unsigned OFS_PMASK = 'h00C;
   localparam int unsigned OFS_SYNC  = 'h010;
   localparam int unsigned OFS_HOLD  = 'h014;
   localparam int unsigned OFS_ROUTE = 'h080;
   localparam int unsigned OFS_ENSET = 'h100;
   localparam int unsigned OFS_ENCLR = 'h180;
   localparam int unsigned OFS_PEND  = 'hD00;
   localparam int unsigned OFS_WAKE  = 'hE00;
   localparam int unsigned OFS_IDENT = 'hFD0;
   localparam int unsigned BANK_STEP = 4;

   typedef struct packed {
      logic ctrl;
      logic kind;
      logic impl;
      logic pmask;
      logic sync;
      logic hold;
      logic ident;
   } sic_sel_t;
endpackage

// File: rtl/sic_decode.sv
module sic_decode
   import sic_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NB     = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output sic_sel_t          sel_o,
   output logic [NB-1:0]     sel_route_o,
   output logic [NB-1:0]     sel_set_o,
   output logic [NB-1:0]     sel_clr_o,
   output logic [NB-1:0]     sel_pend_o,
   output logic [NB-1:0]     sel_wake_o
);
   always_comb begin
      sel_o.ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
      sel_o.kind  = (addr_i == ADDR_W'(OFS_KIND));
      sel_o.impl  = (addr_i == ADDR_W'(OFS_IMPL));
      sel_o.pmask = (addr_i == ADDR_W'(OFS_PMASK));
      sel_o.sync  = (addr_i == ADDR_W'(OFS_SYNC));
      sel_o.hold  = (addr_i == ADDR_W'(OFS_HOLD));
      sel_o.ident = (addr_i == ADDR_W'(OFS_IDENT));
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank_sel
      localparam int unsigned STEP = b * BANK_STEP;
      assign sel_route_o[b] = (addr_i == ADDR_W'(OFS_ROUTE + STEP));
      assign sel_set_o[b]   = (addr_i == ADDR_W'(OFS_ENSET + STEP));
      assign sel_clr_o[b]   = (addr_i == ADDR_W'(OFS_ENCLR + STEP));
      assign sel_pend_o[b]  = (addr_i == ADDR_W'(OFS_PEND  + STEP));
      assign sel_wake_o[b]  = (addr_i == ADDR_W'(OFS_WAKE  + STEP));
   end
endmodule

// File: rtl/sic_bank.sv
module sic_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   input  logic         sel_route_i,
   input  logic         sel_set_i,
   input  logic         sel_clr_i,
   input  logic         sel_wake_i,
   input  logic         wake_allow_i,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] en_o,
   output logic [W-1:0] route_o,
   output logic [W-1:0] wake_o,
   output logic [W-1:0] pend_o,
   output logic         irq_hit_o,
   output logic         fiq_hit_o,
   output logic         wake_hit_o
);
   logic [W-1:0] en_q, route_q, wake_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (wr_en_i && sel_set_i) begin
         en_q <= en_q | wdata_i;
      end else if (wr_en_i && sel_clr_i) begin
         en_q <= en_q & ~wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q <= '0;
      else if (wr_en_i && sel_route_i) route_q <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wake_q <= '0;
      else if (wr_en_i && sel_wake_i && wake_allow_i) wake_q <= wdata_i;
   end

   assign en_o       = en_q;
   assign route_o    = route_q;
   assign wake_o     = wake_q;
   assign pend_o     = src_i & en_q;
   assign irq_hit_o  = |(pend_o & route_q);
   assign fiq_hit_o  = |(pend_o & ~route_q);
   assign wake_hit_o = |(src_i & wake_q);

   // R2: set writes leave every written-one bit enabled
   p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_set_i) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
   // R3: clear writes leave every written-one bit disabled
   p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_clr_i) |=> ((en_q & $past(wdata_i)) == '0));
   // R8: wake mask is untouched while not allowed
   p_wake_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wake_allow_i) |=> (wake_q == $past(wake_q)));
endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
   import sic_pkg::*;
#(
   parameter int unsigned W    = 32,
   parameter int unsigned PM_W = 5,
   parameter int unsigned SY_W = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_en_i,
   input  logic [W-1:0]    wdata_i,
   input  sic_sel_t        sel_i,
   input  logic            fiq_pend_i,
   output logic [W-1:0]    ctrl_o,
   output logic [PM_W-1:0] pmask_o,
   output logic [SY_W-1:0] sync_o,
   output logic            hold_o
);
   logic [W-1:0]    ctrl_q;
   logic [PM_W-1:0] pmask_q;
   logic [SY_W-1:0] sync_q;
   logic            hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         pmask_q <= '0;
         sync_q  <= '0;
         hold_q  <= 1'b0;
      end else if (wr_en_i) begin
         if (sel_i.ctrl)  ctrl_q  <= wdata_i;
         if (sel_i.pmask) pmask_q <= wdata_i[PM_W-1:0];
         if (sel_i.sync)  sync_q  <= wdata_i[SY_W-1:0];
         if (sel_i.hold)  hold_q  <= wdata_i[0] & ~fiq_pend_i;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign pmask_o = pmask_q;
   assign sync_o  = sync_q;
   assign hold_o  = hold_q;

   // R7: a request made while a fast source is pending is refused
   p_hold_deny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_i.hold && fiq_pend_i) |=> !hold_q);
   // R7: holdoff changes only through a holdoff write
   p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && sel_i.hold) |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/secure_intc.sv
module secure_intc
   import sic_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned W       = 32,
   parameter int unsigned NB      = 4,
   parameter int unsigned PM_W    = 5,
   parameter int unsigned SY_W    = 2,
   parameter logic [31:0] IMPL_ID = 32'h0000_0A51,
   parameter logic [31:0] IDENT   = 32'h0000_0C31,
   localparam int unsigned NSRC   = NB * W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      wdata_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   output logic [W-1:0]      rdata_o,
   input  logic [NSRC-1:0]   src_i,
   output logic              irq_o,
   output logic              fiq_o,
   output logic              wake_o
);
   if (ADDR_W < 12) begin : g_bad_addr
      $error("secure_intc: ADDR_W must reach the identification word");
   end
   if (NB < 1 || NB > 32) begin : g_bad_nb
      $error("secure_intc: NB must lie in 1..32");
   end
   if (W != 32) begin : g_bad_w
      $error("secure_intc: bank word must be 32 bits");
   end
   if (PM_W > W || SY_W > W || PM_W < 1 || SY_W < 1) begin : g_bad_fields
      $error("secure_intc: field widths out of range");
   end

   sic_sel_t      sel;
   logic [NB-1:0] sel_route, sel_set, sel_clr, sel_pend, sel_wake;

   sic_decode #(.ADDR_W(ADDR_W), .NB(NB)) u_decode (
      .addr_i      (addr_i),
      .sel_o       (sel),
      .sel_route_o (sel_route),
      .sel_set_o   (sel_set),
      .sel_clr_o   (sel_clr),
      .sel_pend_o  (sel_pend),
      .sel_wake_o  (sel_wake)
   );

   logic [W-1:0]    ctrl;
   logic [PM_W-1:0] pmask;
   logic [SY_W-1:0] sync;
   logic            hold;
   logic [NB-1:0]   irq_hit, fiq_hit, wake_hit;
   logic [W-1:0]    en_w    [NB];
   logic [W-1:0]    route_w [NB];
   logic [W-1:0]    wake_w  [NB];
   logic [W-1:0]    pend_w  [NB];

   sic_ctrl #(.W(W), .PM_W(PM_W), .SY_W(SY_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wdata_i    (wdata_i),
      .sel_i      (sel),
      .fiq_pend_i (|fiq_hit),
      .ctrl_o     (ctrl),
      .pmask_o    (pmask),
      .sync_o     (sync),
      .hold_o     (hold)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      sic_bank #(.W(W)) u_bank (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .wr_en_i      (wr_en_i),
         .wdata_i      (wdata_i),
         .sel_route_i  (sel_route[b]),
         .sel_set_i    (sel_set[b]),
         .sel_clr_i    (sel_clr[b]),
         .sel_wake_i   (sel_wake[b]),
         .wake_allow_i (hold),
         .src_i        (src_i[b*W +: W]),
         .en_o         (en_w[b]),
         .route_o      (route_w[b]),
         .wake_o       (wake_w[b]),
         .pend_o       (pend_w[b]),
         .irq_hit_o    (irq_hit[b]),
         .fiq_hit_o    (fiq_hit[b]),
         .wake_hit_o   (wake_hit[b])
      );
   end

   assign irq_o  = ctrl[0] & (|irq_hit);
   assign fiq_o  = ctrl[0] & (|fiq_hit);
   assign wake_o = hold & (|wake_hit);

   logic [W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      if (sel.ctrl)  rd_word = ctrl;
      if (sel.kind)  rd_word = W'(NSRC);
      if (sel.impl)  rd_word = W'(IMPL_ID);
      if (sel.pmask) rd_word = W'(pmask);
      if (sel.sync)  rd_word = W'(sync);
      if (sel.hold)  rd_word = W'(hold);
      if (sel.ident) rd_word = W'(IDENT);
      for (int b = 0; b < NB; b++) begin
         if (sel_route[b])              rd_word = route_w[b];
         if (sel_set[b] || sel_clr[b])  rd_word = en_w[b];
         if (sel_pend[b])               rd_word = pend_w[b];
         if (sel_wake[b])               rd_word = wake_w[b];
      end
   end

   logic [W-1:0] rdata_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_word;
   end
   assign rdata_o = rdata_q;

   // R5: global enable off silences both request lines
   p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl[0] |-> (!irq_o && !fiq_o));
   // R9: no wake request without a granted holdoff
   p_wake_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hold |-> !wake_o);
   // R10: read data holds when no read is issued
   p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));
   // R4: the two request lines only fire through decoded sources
   p_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i == '0) |-> (!irq_o && !fiq_o && !wake_o));
endmodule

// File: tb/secure_intc_tb.sv
module secure_intc_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [127:0] src = '0;
   logic        irq, fiq, wake;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_en [NB];
   logic [31:0] m_rt [NB];
   logic [31:0] m_wk [NB];
   logic        m_hold;
   logic [31:0] m_ctrl;

   always #(CLK_PERIOD/2) clk = ~clk;

   secure_intc u_dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .src_i(src),
      .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic fiq_pend();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(src[b*32 +: 32] & m_en[b] & ~m_rt[b]);
      return r;
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(src[b*32 +: 32] & m_en[b] & m_rt[b]);
      return r & m_ctrl[0];
   endfunction

   function automatic logic exp_fiq();
      return fiq_pend() & m_ctrl[0];
   endfunction

   function automatic logic exp_wake();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(src[b*32 +: 32] & m_wk[b]);
      return r & m_hold;
   endfunction

   task automatic m_set(input int b, input logic [31:0] d);
      wr(12'h100 + 12'(4*b), d); m_en[b] |= d;
   endtask
   task automatic m_clr(input int b, input logic [31:0] d);
      wr(12'h180 + 12'(4*b), d); m_en[b] &= ~d;
   endtask
   task automatic m_route(input int b, input logic [31:0] d);
      wr(12'h080 + 12'(4*b), d); m_rt[b] = d;
   endtask
   task automatic m_ctl(input logic [31:0] d);
      wr(12'h000, d); m_ctrl = d;
   endtask
   task automatic m_holdw(input logic d);
      logic f = fiq_pend();
      wr(12'h014, {31'b0, d}); m_hold = d & ~f;
   endtask
   task automatic m_wakew(input int b, input logic [31:0] d);
      logic h = m_hold;
      wr(12'hE00 + 12'(4*b), d);
      if (h) m_wk[b] = d;
   endtask

   task automatic chk_lines(input string req);
      #1;
      chk({req, " irq"},  {31'b0, irq},  {31'b0, exp_irq()});
      chk({req, " fiq"},  {31'b0, fiq},  {31'b0, exp_fiq()});
      chk({req, " wake"}, {31'b0, wake}, {31'b0, exp_wake()});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2024));
      for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_rt[b] = '0; m_wk[b] = '0; end
      m_hold = 1'b0; m_ctrl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      src = {128{1'b1}};
      #1;
      chk("R1 irq", {31'b0, irq}, 32'd0);
      chk("R1 fiq", {31'b0, fiq}, 32'd0);
      chk("R1 wake", {31'b0, wake}, 32'd0);
      src = '0;
      for (int b = 0; b < NB; b++) begin
         rd(12'h100 + 12'(4*b), v); chk("R1 enable", v, 32'd0);
         rd(12'h080 + 12'(4*b), v); chk("R1 route", v, 32'd0);
         rd(12'hE00 + 12'(4*b), v); chk("R1 wake mask", v, 32'd0);
      end
      rd(12'h014, v); chk("R1 holdoff", v, 32'd0);
      rd(12'h000, v); chk("R1 control", v, 32'd0);

      // R10 fixed words and reserved offsets
      rd(12'h004, v); chk("R10 type", v, 32'd128);
      rd(12'h008, v); chk("R10 impl", v, 32'h0000_0A51);
      rd(12'hFD0, v); chk("R10 ident", v, 32'h0000_0C31);
      rd(12'hD80, v); chk("R10 hipend", v, 32'd0);
      rd(12'hF00, v); chk("R10 swint", v, 32'd0);
      rd(12'h7FC, v); chk("R10 unmapped", v, 32'd0);
      @(negedge clk); addr = 12'h004;
      @(negedge clk); chk("R10 hold without read", rdata, 32'd0);

      // R5 register readback
      m_ctl(32'h8001_0001);
      rd(12'h000, v); chk("R5 control", v, 32'h8001_0001);
      wr(12'h00C, 32'hFFFF_FFFF);
      rd(12'h00C, v); chk("R5 pmask", v, 32'h0000_001F);
      wr(12'h010, 32'h0000_0002);
      rd(12'h010, v); chk("R5 sync", v, 32'h0000_0002);

      // R2/R3 directed: set with zero bits, clear, edge index
      m_set(3, 32'h8000_0001);
      m_set(3, 32'h0000_0100);
      rd(12'h180 + 12'd12, v); chk("R2 set keeps others", v, 32'h8000_0101);
      m_clr(3, 32'h0000_0001);
      rd(12'h10C, v); chk("R3 clear", v, 32'h8000_0100);
      m_route(3, 32'h8000_0000);
      src = '0; src[127] = 1'b1;
      chk_lines("R4 source 127 to irq");
      m_route(3, 32'h0);
      chk_lines("R4 source 127 to fiq");
      rd(12'hD0C, v); chk("R6 pending edge", v, 32'h8000_0000);

      // R5 gating
      m_ctl(32'h0);
      chk_lines("R5 gated");
      m_ctl(32'h1);

      // R7 refused while fast source pending
      m_holdw(1'b1);
      rd(12'h014, v); chk("R7 refused", v, {31'b0, m_hold});
      chk("R7 refused value", v, 32'd0);
      // R8 wake write ignored while not granted
      m_wakew(0, 32'hFFFF_FFFF);
      rd(12'hE00, v); chk("R8 ignored", v, 32'd0);

      // R7 granted, R8/R9 wake path ignoring enables
      src = '0;
      m_holdw(1'b1);
      rd(12'h014, v); chk("R7 granted", v, 32'd1);
      m_wakew(1, 32'h0000_0010);
      rd(12'hE04, v); chk("R8 accepted", v, 32'h0000_0010);
      src[36] = 1'b1;
      chk_lines("R9 wake disabled source");
      chk("R9 wake high", {31'b0, wake}, 32'd1);
      src[36] = 1'b0; src[37] = 1'b1;
      chk_lines("R9 unmasked source");
      m_holdw(1'b0);
      src[36] = 1'b1;
      chk_lines("R9 released");
      m_wakew(1, 32'h0);
      rd(12'hE04, v); chk("R8 locked after release", v, 32'h0000_0010);
      src = '0;

      // random mix for R2 R3 R4 R6
      for (int it = 0; it < 400; it++) begin
         int b = int'($urandom_range(0, NB-1));
         logic [31:0] d = $urandom() & $urandom();
         case ($urandom_range(0, 3))
            0: m_set(b, d);
            1: m_clr(b, d);
            2: m_route(b, $urandom());
            default: m_ctl({31'b0, ($urandom_range(0, 3) != 0)});
         endcase
         @(negedge clk);
         src = {$urandom() & $urandom() & $urandom(), $urandom() & $urandom() & $urandom(),
                $urandom() & $urandom() & $urandom(), $urandom() & $urandom() & $urandom()};
         chk_lines("R4 random");
         b = int'($urandom_range(0, NB-1));
         rd(12'hD00 + 12'(4*b), v); chk("R6 random pending", v, src[b*32 +: 32] & m_en[b]);
         rd((it % 2 == 0 ? 12'h100 : 12'h180) + 12'(4*b), v);
         chk("R2 R3 random enable", v, m_en[b]);
         rd(12'h080 + 12'(4*b), v); chk("R4 random route", v, m_rt[b]);
      end

      summary();
   end
endmodule